// File: doc/BRIEF.md
# Wakeup Pin Event Controller

This block watches a bank of asynchronous wakeup inputs and records a sticky flag for each pin when a qualifying edge arrives. Every pin has four candidate source lines. A per-pin selection code picks one of them. That line passes through a multi-flop synchroniser and then an edge detector, and a per-pin polarity bit chooses whether a rising or a falling edge counts. An OR of the flags of enabled pins drives a single wakeup request toward the power sequencer.

Software programs the enables, polarities and selections through a small word-addressed register port with a single-cycle write strobe. The same port reads the flags back. A flag is cleared either by writing a one to its bit at the clear address or by disabling the pin. Polarity and selection are locked while a pin is enabled, so a pin cannot be retargeted while it is armed.

Top module: `wkup_evt_ctrl`

## Requirements
- R1: After reset the enable, polarity, selection and flag registers all read 0, and wake_req is 0.
- R2: With polarity 0, a rising edge on the selected source of an enabled pin sets that pin's flag. The flag reads 1 at the third rising clock edge after the input change.
- R3: With polarity 1, a falling edge on the selected source of an enabled pin sets that pin's flag. An edge of the opposite direction leaves the flag at 0.
- R4: Pin p has four source lines, wk_src[4p+3:4p]. Its 2-bit selection code s (bits 2p+1:2p of address 2) picks line wk_src[4p+s]. Edges on the other three lines leave the flag at 0.
- R5: An edge on a pin whose enable bit (bit p of address 0) is 0 does not set its flag.
- R6: A write of 1 to bit p at address 4 clears flag p in that clock edge. A write of 0 to bit p leaves flag p unchanged.
- R7: When pin p's selection code is 3, the clear write to bit p is ignored and the flag stays 1.
- R8: Writing enable bit p to 0 clears flag p at the same clock edge, for any selection code.
- R9: A write to polarity (address 1) or selection (address 2) leaves the bits of pins whose enable is 1 unchanged, and updates the bits of disabled pins. The enable value used is the one held before that write.
- R10: If a flag's set event and its clear write take effect at the same clock edge, the flag ends at 1.
- R11: wake_req is 1 exactly when at least one enabled pin's flag is 1. It stays 1 while any flag remains set.
- R12: The flags read at address 3. Address 4 and any address above 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wk_src | input | PINS*4 | Asynchronous source lines, four per pin |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| wake_req | output | 1 | OR of the flags of enabled pins |

## Verification
The two functions that can land in the same clock edge are the setting of a flag by a synchronised edge and the clearing of that flag by a write to the clear address. The bench changes a source line and then counts the synchroniser and edge registers. It places the clear write so that the write is sampled at exactly the edge where the flag would set. A flag that reads 1 afterwards shows that the set won. A flag that reads 0 shows that the clear was given priority.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   localparam int WK_ADDR_W = 3;

   typedef enum logic [WK_ADDR_W-1:0] {
      REG_ENABLE = 3'd0,
      REG_POLAR  = 3'd1,
      REG_SELECT = 3'd2,
      REG_FLAGS  = 3'd3,
      REG_CLEAR  = 3'd4
   } wk_reg_e;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wkup_cfg_regs.sv
module wkup_cfg_regs
   import wkup_pkg::*;
#(
   parameter int PINS   = 8,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [WK_ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [PINS-1:0]       en_q,
   output logic [PINS-1:0]       en_nxt,
   output logic [PINS-1:0]       pol_q,
   output logic [PINS*SEL_W-1:0] sel_q,
   output logic [PINS-1:0]       clr_req
);
   logic hit_en, hit_pol, hit_sel, hit_clr;
   logic unused_wr_bits;

   assign hit_en  = wr_en && (wr_addr == REG_ENABLE);
   assign hit_pol = wr_en && (wr_addr == REG_POLAR);
   assign hit_sel = wr_en && (wr_addr == REG_SELECT);
   assign hit_clr = wr_en && (wr_addr == REG_CLEAR);
   assign unused_wr_bits = ^wr_data;

   assign en_nxt  = hit_en  ? wr_data[PINS-1:0] : en_q;
   assign clr_req = hit_clr ? wr_data[PINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_q <= '0;
      else        en_q <= en_nxt;

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                   pol_q[p] <= 1'b0;
            else if (hit_pol && !en_q[p]) pol_q[p] <= wr_data[p];

         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)
               sel_q[p*SEL_W +: SEL_W] <= '0;
            else if (hit_sel && !en_q[p])
               sel_q[p*SEL_W +: SEL_W] <= wr_data[p*SEL_W +: SEL_W];
      end
   endgenerate
endmodule

// File: rtl/wkup_pin_cell.sv
module wkup_pin_cell #(
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SRCS       = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRCS-1:0]  src,
   input  logic [SEL_W-1:0] sel,
   input  logic             pol,
   input  logic             en_nxt,
   input  logic             clr,
   output logic             flag
);
   logic picked, synced, prev, evt, clr_ok;

   assign picked = src[sel];

   wkup_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (picked),
      .q     (synced)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= synced;

   assign evt    = pol ? (prev & ~synced) : (synced & ~prev);
   assign clr_ok = clr && (sel != {SEL_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       flag <= 1'b0;
      else if (!en_nxt) flag <= 1'b0;
      else              flag <= evt | (flag & ~clr_ok);
endmodule

// File: rtl/wkup_evt_ctrl.sv
module wkup_evt_ctrl
   import wkup_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int SEL_W       = 2,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int SRCS       = 1 << SEL_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PINS*SRCS-1:0]  wk_src,
   input  logic                  wr_en,
   input  logic [WK_ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [WK_ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  wake_req
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wkup_evt_ctrl: SYNC_STAGES must be at least 2");
      end
      if (PINS * SEL_W > DATA_W) begin : g_bad_width
         $error("wkup_evt_ctrl: selection fields do not fit DATA_W");
      end
   endgenerate

   logic [PINS-1:0]       en_q, en_nxt, pol_q, clr_req, flags;
   logic [PINS*SEL_W-1:0] sel_q;

   wkup_cfg_regs #(.PINS(PINS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .en_q    (en_q),
      .en_nxt  (en_nxt),
      .pol_q   (pol_q),
      .sel_q   (sel_q),
      .clr_req (clr_req)
   );

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_cell
         wkup_pin_cell #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (wk_src[p*SRCS +: SRCS]),
            .sel    (sel_q[p*SEL_W +: SEL_W]),
            .pol    (pol_q[p]),
            .en_nxt (en_nxt[p]),
            .clr    (clr_req[p]),
            .flag   (flags[p])
         );
      end
   endgenerate

   assign wake_req = |(flags & en_q);

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         REG_ENABLE: rd_data[PINS-1:0]       = en_q;
         REG_POLAR:  rd_data[PINS-1:0]       = pol_q;
         REG_SELECT: rd_data[PINS*SEL_W-1:0] = sel_q;
         REG_FLAGS:  rd_data[PINS-1:0]       = flags;
         default:    rd_data                 = '0;
      endcase
   end
endmodule

// File: rtl/wkup_evt_chk.sv
module wkup_evt_chk #(
   parameter int PINS  = 8,
   parameter int SEL_W = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [PINS-1:0]       en_q,
   input logic [PINS-1:0]       pol_q,
   input logic [PINS*SEL_W-1:0] sel_q,
   input logic [PINS-1:0]       flags,
   input logic                  wake_req
);
   logic [PINS-1:0] sticky_sel;

   always_comb
      for (int p = 0; p < PINS; p++)
         sticky_sel[p] = (sel_q[p*SEL_W +: SEL_W] == {SEL_W{1'b1}});

   // R8: no flag survives on a disabled pin
   assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~en_q) == '0);

   // R11: request only with some flag set, and always with one
   assert_req_matches_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req == (flags != '0));

   // R9: polarity of a pin enabled in the prior cycle does not move
   assert_pol_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pol_q ^ $past(pol_q)) & $past(en_q)) == '0);

   // R9: selection of an enabled pin does not move
   assert_sel_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == $past(en_q) && en_q == {PINS{1'b1}}) |-> $stable(sel_q));

   // R7: a pin on selection 3 that stays enabled keeps its flag
   assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flags) & ~flags & en_q & $past(en_q) & sticky_sel) == '0);
endmodule

bind wkup_evt_ctrl wkup_evt_chk #(.PINS(PINS), .SEL_W(SEL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_q     (en_q),
   .pol_q    (pol_q),
   .sel_q    (sel_q),
   .flags    (flags),
   .wake_req (wake_req)
);

// File: tb/test_wkup_evt_ctrl.sv
`timescale 1ns/1ps
module test_wkup_evt_ctrl;
   localparam int PINS = 8;
   localparam int DW   = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PINS*4-1:0] wk_src = '0;
   logic            wr_en = 1'b0;
   logic [2:0]      wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic [2:0]      rd_addr = '0;
   logic [DW-1:0]   rd_data;
   logic            wake_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wkup_evt_ctrl i_wkup_evt_ctrl (
      .clk(clk), .rst_n(rst_n), .wk_src(wk_src), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .wake_req(wake_req)
   );

   // vector: {pin[2:0], sel[1:0], pol, rise, line[1:0], expect}
   localparam logic [9:0] VEC [8] = '{
      {3'd0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1},
      {3'd3, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1},
      {3'd5, 2'd2, 1'b0, 1'b1, 2'd1, 1'b0},
      {3'd7, 2'd3, 1'b1, 1'b0, 2'd3, 1'b1},
      {3'd2, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0},
      {3'd6, 2'd2, 1'b1, 1'b1, 2'd2, 1'b0},
      {3'd1, 2'd1, 1'b0, 1'b1, 2'd1, 1'b1},
      {3'd4, 2'd3, 1'b0, 1'b1, 2'd3, 1'b1}
   };

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic set_line(input int idx, input logic v);
      @(negedge clk);
      wk_src[idx] = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all-requirements actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(3'(a), v);
         chk("R1 reset register", v, '0);
      end
      chk("R1 reset wake_req", {31'd0, wake_req}, 32'd0);

      // R2 R3 R4 vector walk
      for (int k = 0; k < 8; k++) begin
         int pin, line, idx;
         logic [1:0] sel;
         logic pol, rise, ex;
         pin  = int'(VEC[k][9:7]);
         sel  = VEC[k][6:5];
         pol  = VEC[k][4];
         rise = VEC[k][3];
         line = int'(VEC[k][2:1]);
         ex   = VEC[k][0];
         idx  = pin * 4 + line;
         wr(3'd0, '0);
         @(negedge clk);
         wk_src = '0;
         wk_src[idx] = ~rise;
         settle();
         wr(3'd2, DW'(sel) << (2 * pin));
         wr(3'd1, DW'(pol) << pin);
         wr(3'd0, DW'(1) << pin);
         settle();
         set_line(idx, rise);
         settle();
         rd(3'd3, v);
         chk($sformatf("R2 R3 R4 vector %0d flags", k), v, DW'(ex) << pin);
         chk($sformatf("R11 vector %0d wake_req", k), {31'd0, wake_req}, {31'd0, ex});
      end

      // R5 disabled pin ignores edges
      wr(3'd0, '0);
      @(negedge clk); wk_src = '0;
      wr(3'd2, '0); wr(3'd1, '0);
      settle();
      set_line(0, 1'b1);
      settle();
      rd(3'd3, v);
      chk("R5 disabled pin flag", v, '0);
      set_line(0, 1'b0);

      // R6 write-1 clear, write-0 no effect
      wr(3'd0, 32'h01);
      settle();
      set_line(0, 1'b1);
      settle();
      rd(3'd3, v);
      chk("R2 flag pin0 set", v, 32'h01);
      wr(3'd4, 32'hFE);
      rd(3'd3, v);
      chk("R6 zero clear bit keeps flag", v, 32'h01);
      wr(3'd4, 32'h01);
      rd(3'd3, v);
      chk("R6 clear flag pin0", v, '0);
      chk("R11 wake_req low after clear", {31'd0, wake_req}, 32'd0);

      // R9 polarity and selection locked for enabled pin0
      wr(3'd1, 32'hFF);
      rd(3'd1, v);
      chk("R9 polarity lock", v, 32'hFE);
      wr(3'd2, 32'hFFFF);
      rd(3'd2, v);
      chk("R9 selection lock", v, 32'hFFFC);

      // R7 sticky under selection 3, R8 disable clears
      wr(3'd0, '0);
      wr(3'd1, '0);
      @(negedge clk); wk_src = '0;
      settle();
      wr(3'd0, 32'h82);
      settle();
      set_line(7 * 4 + 3, 1'b1);
      set_line(1 * 4 + 3, 1'b1);
      settle();
      rd(3'd3, v);
      chk("R7 flags set", v, 32'h82);
      wr(3'd4, 32'h82);
      rd(3'd3, v);
      chk("R7 clear ignored on selection 3", v, 32'h82);
      wr(3'd0, 32'h02);
      rd(3'd3, v);
      chk("R8 disable clears flag", v, 32'h02);
      chk("R11 wake_req with one flag left", {31'd0, wake_req}, 32'd1);
      wr(3'd0, '0);
      rd(3'd3, v);
      chk("R8 disable clears selection-3 flag", v, '0);

      // R10 set and clear at the same edge
      wr(3'd2, '0);
      @(negedge clk); wk_src = '0;
      settle();
      wr(3'd0, 32'h04);
      settle();
      @(negedge clk); wk_src[8] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h04;
      @(negedge clk);
      wr_en = 1'b0;
      rd(3'd3, v);
      chk("R10 set wins over clear", v, 32'h04);

      // R12 read map
      rd(3'd4, v);
      chk("R12 clear address reads 0", v, '0);
      rd(3'd6, v);
      chk("R12 unmapped address reads 0", v, '0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule